// File: doc/BRIEF.md
# Serial Flash Ready Poller

This block is a host-side SPI master whose only job is to wait for a serial flash device to finish an internally timed program or erase operation. A one-cycle `start` pulse makes it pull chip select low and shift out the status-read command. If the serial clock is fast, it also sends one all-zero filler byte. It then keeps the clock running and reads status bytes back to back under the same chip-select assertion. The device repeats its status register for as long as chip select stays low, so the command is never sent again.

Every received status byte is tested for the ready flag. The first byte that shows ready ends the transaction: chip select is released and `done` pulses for one cycle. If a configurable number of status bytes arrive without ready, the block gives up, releases chip select and pulses `timeout` instead. The sector-protect flag and the 4-bit density code from the last status byte stay visible on the outputs. The serial clock divider and the poll limit are parameters. Whether a filler byte is sent is chosen per transaction by the `fast_sck` input.

Top module: `flash_ready_poller`

## Requirements
- R1: A `start` pulse while idle drives `spi_cs_n` low on the next clock and shifts out the command byte 0xD7, most significant bit first, in SPI mode 0. SCK idles low, MOSI changes only after a falling SCK edge, and MISO is sampled on the rising edge.
- R2: When `fast_sck` is 1 at the `start` pulse, eight zero bits follow the command before the first status bit is sampled. When it is 0, status sampling begins right after the command's eighth bit.
- R3: Status bytes are assembled MSB first, one after another, under a single chip-select assertion, and MOSI stays 0 after the command byte.
- R4: The first status byte with bit 7 = 1 ends polling. After the falling SCK edge that follows that byte, `spi_cs_n` goes high and `done` is high for exactly one clock.
- R5: `protect` equals bit 1 and `density` equals bits 5..2 of the last status byte received. Both hold their value until a later status byte completes.
- R6: If MAX_POLLS status bytes in a row show bit 7 = 0, chip select is released and `timeout` pulses for one clock. `done` does not pulse, and `done` and `timeout` are never high together.
- R7: A `start` pulse while `busy` is high has no effect: no second chip-select assertion occurs.
- R8: Between two transactions `spi_cs_n` stays high for at least one full SCK period (2*HALF_DIV clocks), and SCK is low whenever `spi_cs_n` is high.
- R9: After reset `spi_cs_n`=1, `spi_sck`=0, and `busy`, `done`, `timeout`, `protect` and `density` are all 0.
- R10: The SCK period inside a transaction is exactly 2*HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a poll transaction (one-cycle pulse) |
| fast_sck | input | 1 | Insert the filler byte after the command |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Transaction or inter-transaction gap in progress |
| done | output | 1 | One-cycle pulse: device reported ready |
| timeout | output | 1 | One-cycle pulse: poll limit reached |
| protect | output | 1 | Sector-protect flag from last status byte |
| density | output | 4 | Density code from last status byte |

## Verification
The in-line assertions watch, on every cycle, the properties that hold at any time. These are the single-cycle `done`/`timeout` pulses and their mutual exclusion, a low SCK whenever chip select is high, and the minimum chip-select high time. They also cover MOSI holding steady between falling-edge strobes and the status fields changing only when a status byte completes. Other properties depend on what the device sends, and only the bench scenarios, driven by a behavioural flash model, can show them. These are the exact command bits, the presence of the filler byte, the number of status bytes consumed before ready or timeout, the field values latched from the final byte, and the measured SCK period.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  localparam logic [7:0] RDSTAT_CMD = 8'hD7;
  localparam int         RDY_POS    = 7;
  localparam int         PROT_POS   = 1;
  localparam int         DENS_LO    = 2;
  localparam int         DENS_W     = 4;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_CMD,
    PS_FILL,
    PS_STAT,
    PS_CLOSE,
    PS_GAP
  } poll_state_e;

endpackage

// File: rtl/fpoll_sck_gen.sv
module fpoll_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic fall
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] WRAP_AT = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          wrap;

  assign wrap = (cnt_q == WRAP_AT);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck  = sck_q;
  assign rise = run & wrap & ~sck_q;
  assign fall = run & wrap &  sck_q;

  // R10: each strobe moves the clock level the way it names
  a_r10_rise_sets_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> sck_q);
  a_r10_fall_sets_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !sck_q);

endmodule

// File: rtl/fpoll_shifter.sv
module fpoll_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rise,
  input  logic         fall,
  input  logic         miso,
  output logic         mosi,
  output logic         byte_end,
  output logic [W-1:0] rx_byte
);

  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  logic [W-1:0]  tx_q, tx_d;
  logic [W-1:0]  rx_q, rx_d;
  logic [BW-1:0] bit_q, bit_d;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    bit_d = bit_q;
    if (load) begin
      tx_d  = load_val;
      rx_d  = '0;
      bit_d = '0;
    end else begin
      if (fall) tx_d = {tx_q[W-2:0], 1'b0};
      if (rise) begin
        rx_d  = {rx_q[W-2:0], miso};
        bit_d = (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      bit_q <= bit_d;
    end
  end

  assign mosi     = tx_q[W-1];
  assign rx_byte  = {rx_q[W-2:0], miso};
  assign byte_end = rise && (bit_q == LAST_BIT);

  // R1: outgoing data only moves on a falling-edge strobe or a fresh load
  a_r1_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !load) |=> $stable(mosi));

endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
  import fpoll_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int MAX_POLLS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fast_sck,
  input  logic              sck,
  input  logic              fall,
  input  logic              byte_end,
  input  logic [7:0]        rx_byte,
  output logic              run,
  output logic              load,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              protect,
  output logic [DENS_W-1:0] density
);

  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int PW      = $clog2(MAX_POLLS + 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);
  localparam logic [GW-1:0] GAP_FULL  = GW'(GAP_CYC);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);
  localparam logic [PW-1:0] POLL_MAX  = PW'(MAX_POLLS);

  poll_state_e       state_q, state_d;
  logic              fast_q, fast_d;
  logic              ok_q, ok_d;
  logic              cs_n_q, cs_n_d;
  logic              run_q, run_d;
  logic              done_q, done_d;
  logic              tmo_q, tmo_d;
  logic              prot_q, prot_d;
  logic [DENS_W-1:0] dens_q, dens_d;
  logic [PW-1:0]     polls_q, polls_d;
  logic [GW-1:0]     gap_q, gap_d;

  always_comb begin
    state_d = state_q;
    fast_d  = fast_q;
    ok_d    = ok_q;
    cs_n_d  = cs_n_q;
    run_d   = run_q;
    done_d  = 1'b0;
    tmo_d   = 1'b0;
    prot_d  = prot_q;
    dens_d  = dens_q;
    polls_d = polls_q;
    gap_d   = gap_q;
    load    = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (start) begin
          load    = 1'b1;
          fast_d  = fast_sck;
          polls_d = '0;
          cs_n_d  = 1'b0;
          run_d   = 1'b1;
          state_d = PS_CMD;
        end
      end
      PS_CMD: begin
        if (byte_end) state_d = fast_q ? PS_FILL : PS_STAT;
      end
      PS_FILL: begin
        if (byte_end) state_d = PS_STAT;
      end
      PS_STAT: begin
        if (byte_end) begin
          prot_d  = rx_byte[PROT_POS];
          dens_d  = rx_byte[DENS_LO +: DENS_W];
          polls_d = polls_q + 1'b1;
          if (rx_byte[RDY_POS]) begin
            ok_d    = 1'b1;
            state_d = PS_CLOSE;
          end else if (polls_q == POLL_LAST) begin
            ok_d    = 1'b0;
            state_d = PS_CLOSE;
          end
        end
      end
      PS_CLOSE: begin
        if (fall) begin
          cs_n_d  = 1'b1;
          run_d   = 1'b0;
          done_d  = ok_q;
          tmo_d   = ~ok_q;
          gap_d   = '0;
          state_d = PS_GAP;
        end
      end
      PS_GAP: begin
        if (gap_q == GAP_LAST) state_d = PS_IDLE;
        else                   gap_d   = gap_q + 1'b1;
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      fast_q  <= 1'b0;
      ok_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      prot_q  <= 1'b0;
      dens_q  <= '0;
      polls_q <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      fast_q  <= fast_d;
      ok_q    <= ok_d;
      cs_n_q  <= cs_n_d;
      run_q   <= run_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
      prot_q  <= prot_d;
      dens_q  <= dens_d;
      polls_q <= polls_d;
      gap_q   <= gap_d;
    end
  end

  assign run     = run_q;
  assign cs_n    = cs_n_q;
  assign busy    = (state_q != PS_IDLE);
  assign done    = done_q;
  assign timeout = tmo_q;
  assign protect = prot_q;
  assign density = dens_q;

  // Checker state: consecutive cycles with chip select high, saturating
  logic [GW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_cnt_q <= GAP_FULL;
    else if (!cs_n_q)         hi_cnt_q <= '0;
    else if (hi_cnt_q != GAP_FULL) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  a_r1_start_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (!cs_n_q && busy));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r4_release_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || tmo_q) |-> cs_n_q);
  a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_end && state_q == PS_STAT) |=> ($stable(prot_q) && $stable(dens_q)));
  a_r6_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> !tmo_q);
  a_r6_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && tmo_q));
  a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= POLL_MAX);
  a_r8_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck);
  a_r8_min_high_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> ($past(hi_cnt_q) >= GAP_LAST));

endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
  import fpoll_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int MAX_POLLS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        fast_sck,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic        protect,
  output logic [3:0]  density
);

  logic       run, rise, fall, load, byte_end;
  logic [7:0] rx_byte;

  fpoll_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sck   (spi_sck),
    .rise  (rise),
    .fall  (fall)
  );

  fpoll_shifter #(.W(8)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (RDSTAT_CMD),
    .rise     (rise),
    .fall     (fall),
    .miso     (spi_miso),
    .mosi     (spi_mosi),
    .byte_end (byte_end),
    .rx_byte  (rx_byte)
  );

  fpoll_ctrl #(.HALF_DIV(HALF_DIV), .MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fast_sck (fast_sck),
    .sck      (spi_sck),
    .fall     (fall),
    .byte_end (byte_end),
    .rx_byte  (rx_byte),
    .run      (run),
    .load     (load),
    .cs_n     (spi_cs_n),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .protect  (protect),
    .density  (density)
  );

endmodule

// File: tb/flash_ready_poller_test.sv
`timescale 1ns/1ps
module flash_ready_poller_test;

  localparam int HALF  = 2;
  localparam int MAXP  = 4;
  localparam int CLKNS = 8;
  localparam int SCKNS = 2 * HALF * CLKNS;

  logic clk, rst_n, start, fast_sck, miso;
  logic sck, cs_n, mosi, busy, done, timeout, protect;
  logic [3:0] density;

  flash_ready_poller #(.HALF_DIV(HALF), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fast_sck(fast_sck),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .busy(busy), .done(done), .timeout(timeout), .protect(protect),
    .density(density)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  initial clk = 1'b0;
  always #(CLKNS/2) clk = ~clk;

  // ---------- behavioural flash model ----------
  logic       m_fast;
  int         m_busy_n;
  logic       m_prot;
  logic [3:0] m_dens;
  int         rises, ones_late, cs_falls, per_bad, hi_run, last_gap;
  logic [7:0] cmd_rx;
  longint     last_rise;

  function automatic logic model_bit(int k);
    int hdr;
    int s;
    logic [7:0] b;
    hdr = m_fast ? 16 : 8;
    if (k < hdr) return 1'b0;
    s = k - hdr;
    b = ((s / 8) < m_busy_n) ? {1'b0, 1'b1, ~m_dens, ~m_prot, 1'b0}
                             : {1'b1, 1'b0,  m_dens,  m_prot, 1'b1};
    return b[7 - (s % 8)];
  endfunction

  always @(negedge cs_n) begin
    rises = 0; cmd_rx = 8'h00; ones_late = 0; miso = 1'b0;
    cs_falls++;
    last_gap = hi_run;
  end

  always @(posedge sck) if (!cs_n) begin
    if (rises < 8) cmd_rx = {cmd_rx[6:0], mosi};
    else if (mosi) ones_late++;
    if (rises > 0 && ($time - last_rise) != SCKNS) per_bad++;
    last_rise = $time;
    rises++;
  end

  always @(negedge sck) if (!cs_n) miso = model_bit(rises);

  always @(negedge clk) begin
    cyc++;
    if (cs_n) hi_run++; else hi_run = 0;
  end

  int n_done = 0, n_tmo = 0;
  always @(negedge clk) begin
    if (done) n_done++;
    if (timeout) n_tmo++;
  end

  task automatic chk(string req, logic ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_end(int d0, int t0);
    for (int i = 0; i < 20000; i++) begin
      if (n_done != d0 || n_tmo != t0) break;
      @(negedge clk);
    end
  endtask

  // one complete poll, checks R1 R2 R3 R4 R5 R6 R10
  task automatic run_poll(logic fast, int busy_n, logic prot, logic [3:0] dens);
    int d0, t0, hdr, nst, exp_n;
    logic exp_to;
    m_fast = fast; m_busy_n = busy_n; m_prot = prot; m_dens = dens;
    per_bad = 0;
    d0 = n_done; t0 = n_tmo;
    exp_to = (busy_n >= MAXP);
    exp_n  = exp_to ? MAXP : busy_n + 1;
    @(negedge clk); start = 1'b1; fast_sck = fast;
    @(negedge clk); start = 1'b0;
    chk("R1 cs low after start", cs_n == 1'b0, cs_n, 0);
    wait_end(d0, t0);
    chk("R4 cs released at end", cs_n == 1'b1, cs_n, 1);
    hdr = fast ? 16 : 8;
    nst = (rises - hdr) / 8;
    chk("R1 command byte", cmd_rx == 8'hD7, cmd_rx, 8'hD7);
    chk("R2 header alignment", ((rises - hdr) % 8) == 0, rises, hdr + 8 * exp_n);
    chk("R3 status byte count", nst == exp_n, nst, exp_n);
    chk("R3 mosi zero after command", ones_late == 0, ones_late, 0);
    chk("R4 done pulses", (n_done - d0) == (exp_to ? 0 : 1), n_done - d0, exp_to ? 0 : 1);
    chk("R6 timeout pulses", (n_tmo - t0) == (exp_to ? 1 : 0), n_tmo - t0, exp_to ? 1 : 0);
    chk("R5 protect", protect == (exp_to ? ~prot : prot), protect, exp_to ? ~prot : prot);
    chk("R5 density", density == (exp_to ? ~dens : dens), density, exp_to ? ~dens : dens);
    chk("R10 sck period", per_bad == 0, per_bad, 0);
    repeat (2 * HALF + 3) @(negedge clk);
    chk("R8 idle again", busy == 1'b0, busy, 0);
  endtask

  task automatic test_reset();
    chk("R9 cs_n", cs_n == 1'b1, cs_n, 1);
    chk("R9 sck", sck == 1'b0, sck, 0);
    chk("R9 busy", busy == 1'b0, busy, 0);
    chk("R9 done/timeout", (done | timeout) == 1'b0, {done, timeout}, 0);
    chk("R9 fields", {protect, density} == 5'd0, {protect, density}, 0);
  endtask

  task automatic test_ignore_start();
    int c0, d0;
    m_fast = 1'b0; m_busy_n = 3; m_prot = 1'b1; m_dens = 4'hA;
    c0 = cs_falls; d0 = n_done;
    @(negedge clk); start = 1'b1; fast_sck = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1; fast_sck = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_end(d0, n_tmo);
    repeat (2 * HALF + 3) @(negedge clk);
    chk("R7 single cs assertion", (cs_falls - c0) == 1, cs_falls - c0, 1);
    chk("R7 single done", (n_done - d0) == 1, n_done - d0, 1);
  endtask

  task automatic test_gap();
    int c0;
    m_fast = 1'b0; m_busy_n = 0; m_prot = 1'b0; m_dens = 4'h3;
    c0 = cs_falls;
    @(negedge clk); start = 1'b1; fast_sck = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (cs_falls - c0 >= 2) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8 back-to-back transactions", (cs_falls - c0) == 2, cs_falls - c0, 2);
    chk("R8 cs high gap", last_gap >= 2 * HALF, last_gap, 2 * HALF);
    wait_end(n_done, n_tmo);
    repeat (2 * HALF + 3) @(negedge clk);
  endtask

  initial begin
    for (;;) begin
      @(negedge clk);
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; fast_sck = 1'b0; miso = 1'b0;
    m_fast = 1'b0; m_busy_n = 0; m_prot = 1'b0; m_dens = 4'h0;
    rises = 0; ones_late = 0; cs_falls = 0; per_bad = 0;
    hi_run = 0; last_gap = 0; cmd_rx = 8'h00; last_rise = 0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_poll(1'b0, 0, 1'b1, 4'b1101);
    run_poll(1'b0, 2, 1'b0, 4'b0110);
    run_poll(1'b1, 0, 1'b0, 4'b1001);
    run_poll(1'b1, 3, 1'b1, 4'b0011);
    run_poll(1'b0, MAXP, 1'b1, 4'b0101);
    run_poll(1'b1, MAXP + 2, 1'b0, 4'b1110);
    test_ignore_start();
    test_gap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule